// File: doc/BRIEF.md
# ECC Error Log Register

This block sits beside a memory controller's ECC decoder and records memory errors for software. Each cycle the decoder may raise an error strobe with a flag that marks the error as correctable (single-bit) or uncorrectable (multi-bit). The strobe comes with the failing address and the 8-bit syndrome. The block keeps a single 32-bit register that software reads and writes. The register holds three control bits, the upper part of the logged address, the logged syndrome, and two status flags that software clears by writing 1.

Only the first error after a clear is logged. Its kind decides which status flag rises. While a flag is set, later errors of either kind leave the log unchanged. Software empties the log by writing 1 to both flags in the same write. Two level outputs request an NMI for a logged correctable error and a system error for a logged uncorrectable error, each gated by its own enable bit. A combinational output tells the datapath to write corrected data back to memory, unless software has disabled scrubbing.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the register reads 0, and `nmi_req`, `serr_req` and `scrub_wb` are 0 while no error strobe is present.
- R2: Bits 31 (scrub disable), 3 (system-error enable) and 2 (NMI enable) are loaded from `reg_wdata` on every write and read back unchanged.
- R3: `scrub_wb` is 1 in a cycle exactly when `err_valid` is 1, `err_uncorr` is 0 and bit 31 is 0. It is 0 for uncorrectable errors and while bit 31 is 1.
- R4: When an error is logged, bits 30:12 read as the top 19 bits of `err_addr` and bits 11:4 read as `err_syn`, starting from the cycle after the strobe.
- R5: A strobe while the log is empty sets bit 0 if `err_uncorr` is 0 and sets bit 1 if `err_uncorr` is 1. The two flags are never both 1.
- R6: While either flag is set, later strobes of either kind change neither flag, and bits 30:4 hold their value.
- R7: A write with bits 1:0 equal to 2'b11 clears both flags. A write with 2'b01, 2'b10 or 2'b00 in those bits leaves the flags unchanged.
- R8: A strobe in the same cycle as a clearing write is logged, with its flag, address and syndrome, as if the log had been empty.
- R9: `nmi_req` equals bit 0 AND bit 2, and `serr_req` equals bit 1 AND bit 3, at all times.
- R10: Writes do not alter bits 30:4, whatever `reg_wdata` holds in those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Error strobe from the ECC decoder, one cycle per error |
| err_uncorr | input | 1 | 1 = uncorrectable (multi-bit), 0 = corrected (single-bit) |
| err_addr | input | ADDR_W | Failing memory address |
| err_syn | input | 8 | ECC syndrome of the failing word |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register contents |
| nmi_req | output | 1 | Level NMI request |
| serr_req | output | 1 | Level system-error request |
| scrub_wb | output | 1 | Write corrected data back for the current read |

## Verification
The bench builds the block with `ADDR_W` = 24. The captured field is then bits 23:5 of the address, so both the slicing variant and the dropped low bits are exercised. It sweeps all 256 syndromes, alternating error kinds, with an address computed from the loop index. Each logged value is compared with a register word built arithmetically. It also walks all four values of the clear bits and all four enable combinations against both error kinds, and it places a strobe on the same edge as a clear.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
   localparam int unsigned REG_W     = 32;
   localparam int unsigned SYN_W     = 8;
   localparam int unsigned ADDR_KEEP = 19;

   // bit positions software depends on
   localparam int unsigned B_SBE     = 0;
   localparam int unsigned B_MBE     = 1;
   localparam int unsigned B_NMI_EN  = 2;
   localparam int unsigned B_SERR_EN = 3;
   localparam int unsigned SYN_LO    = 4;
   localparam int unsigned SYN_HI    = SYN_LO + SYN_W - 1;
   localparam int unsigned ADR_LO    = SYN_HI + 1;
   localparam int unsigned ADR_HI    = ADR_LO + ADDR_KEEP - 1;
   localparam int unsigned B_SCRUB   = ADR_HI + 1;

   typedef struct packed {
      logic scrub_dis;
      logic serr_en;
      logic nmi_en;
   } ctrl_t;

   typedef enum logic [1:0] {
      LOG_EMPTY = 2'b00,
      LOG_SBE   = 2'b01,
      LOG_MBE   = 2'b10
   } log_state_e;
endpackage

// File: rtl/ecc_err_log_ctrl.sv
module ecc_err_log_ctrl
   import ecc_err_log_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output ctrl_t            ctrl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (we) begin
         ctrl.scrub_dis <= wdata[B_SCRUB];
         ctrl.serr_en   <= wdata[B_SERR_EN];
         ctrl.nmi_en    <= wdata[B_NMI_EN];
      end
   end
endmodule

// File: rtl/ecc_err_log_capture.sv
module ecc_err_log_capture
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 err_valid,
   input  logic                 err_uncorr,
   input  logic [ADDR_W-1:0]    err_addr,
   input  logic [SYN_W-1:0]     err_syn,
   input  logic                 clr,
   output log_state_e           state,
   output logic [ADDR_KEEP-1:0] addr_q,
   output logic [SYN_W-1:0]     syn_q
);
   logic [ADDR_KEEP-1:0] addr_top;
   logic                 room;

   generate
      if (ADDR_W == ADDR_KEEP) begin : g_addr_full
         assign addr_top = err_addr;
      end else begin : g_addr_slice
         assign addr_top = err_addr[ADDR_W-1 -: ADDR_KEEP];
      end
   endgenerate

   // a clear in the same cycle frees the log for the incoming error
   assign room = (state == LOG_EMPTY) || clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= LOG_EMPTY;
         addr_q <= '0;
         syn_q  <= '0;
      end else if (err_valid && room) begin
         state  <= err_uncorr ? LOG_MBE : LOG_SBE;
         addr_q <= addr_top;
         syn_q  <= err_syn;
      end else if (clr) begin
         state  <= LOG_EMPTY;
      end
   end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_valid,
   input  logic              err_uncorr,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [7:0]        err_syn,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              nmi_req,
   output logic              serr_req,
   output logic              scrub_wb
);
   generate
      if (ADDR_W < ADDR_KEEP) begin : g_bad_addr
         $error("ADDR_W must be at least ADDR_KEEP");
      end
      if (B_SCRUB != REG_W - 1) begin : g_bad_layout
         $error("register fields do not fill the word");
      end
   endgenerate

   ctrl_t                ctrl;
   log_state_e           state;
   logic [ADDR_KEEP-1:0] addr_q;
   logic [SYN_W-1:0]     syn_q;
   logic                 clr;

   assign clr = reg_we && reg_wdata[B_SBE] && reg_wdata[B_MBE];

   ecc_err_log_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .wdata (reg_wdata),
      .ctrl  (ctrl)
   );

   ecc_err_log_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_valid  (err_valid),
      .err_uncorr (err_uncorr),
      .err_addr   (err_addr),
      .err_syn    (err_syn),
      .clr        (clr),
      .state      (state),
      .addr_q     (addr_q),
      .syn_q      (syn_q)
   );

   assign reg_rdata = {ctrl.scrub_dis, addr_q, syn_q, ctrl.serr_en, ctrl.nmi_en,
                       state == LOG_MBE, state == LOG_SBE};

   assign nmi_req  = (state == LOG_SBE) && ctrl.nmi_en;
   assign serr_req = (state == LOG_MBE) && ctrl.serr_en;
   assign scrub_wb = err_valid && !err_uncorr && !ctrl.scrub_dis;
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        err_valid,
   input logic        err_uncorr,
   input logic        reg_we,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        nmi_req,
   input logic        serr_req,
   input logic        scrub_wb
);
   logic logged, clr_w;
   assign logged = reg_rdata[0] || reg_rdata[1];
   assign clr_w  = reg_we && (reg_wdata[1:0] == 2'b11);

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rdata[0] && reg_rdata[1])); // R5
   AST_FIRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!logged && err_valid) |=> (reg_rdata[1:0] == (err_uncorr_q ? 2'b10 : 2'b01))); // R5
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (logged && !clr_w) |=> ($stable(reg_rdata[30:0]) || $past(reg_we))); // R6
   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (logged && !clr_w) |=> $stable(reg_rdata[30:4])); // R6
   AST_NOCLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (logged && reg_we && reg_wdata[1:0] != 2'b11) |=> $stable(reg_rdata[1:0])); // R7
   AST_SIM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && err_valid) |=> (reg_rdata[1:0] != 2'b00)); // R8
   AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req == (reg_rdata[0] && reg_rdata[2])); // R9
   AST_SERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      serr_req == (reg_rdata[1] && reg_rdata[3])); // R9
   AST_SCRUB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      scrub_wb |-> (err_valid && !err_uncorr && !reg_rdata[31])); // R3

   logic err_uncorr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_uncorr_q <= 1'b0;
      else        err_uncorr_q <= err_uncorr;
   end
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .err_valid  (err_valid),
   .err_uncorr (err_uncorr),
   .reg_we     (reg_we),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .nmi_req    (nmi_req),
   .serr_req   (serr_req),
   .scrub_wb   (scrub_wb)
);

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          err_valid = 1'b0;
   logic          err_uncorr = 1'b0;
   logic [AW-1:0] err_addr = '0;
   logic [7:0]    err_syn = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          nmi_req, serr_req, scrub_wb;

   int checks = 0;
   int errors = 0;
   logic [2:0] ctl = 3'b000; // {scrub_dis, serr_en, nmi_en}

   always #5 clk = ~clk;

   ecc_err_log #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_uncorr(err_uncorr),
      .err_addr(err_addr), .err_syn(err_syn), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .nmi_req(nmi_req), .serr_req(serr_req), .scrub_wb(scrub_wb)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input logic [AW-1:0] a, input logic [7:0] s,
                                        input logic [1:0] flags);
      return {ctl[2], a[AW-1:AW-19], s, ctl[1], ctl[0], flags};
   endfunction

   task automatic wr(input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
   endtask

   function automatic logic [31:0] ctlw(input logic [1:0] clrbits, input logic [26:0] junk);
      return {ctl[2], junk, ctl[1], ctl[0], clrbits};
   endfunction

   task automatic strobe(input logic unc, input logic [AW-1:0] a, input logic [7:0] s);
      @(negedge clk); err_valid = 1'b1; err_uncorr = unc; err_addr = a; err_syn = s;
      #1;
      chk("R3", {31'b0, scrub_wb}, {31'b0, !unc && !ctl[2]});
      @(negedge clk); err_valid = 1'b0; err_uncorr = 1'b0;
   endtask

   initial begin : watchdog
      #1500000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] a0, a1;
      repeat (3) @(negedge clk);
      chk("R1", reg_rdata, 32'h0);
      chk("R1", {30'b0, nmi_req, serr_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {31'b0, scrub_wb}, 32'h0);

      // R2 control bits, R10 read-only fields ignore writes
      for (int k = 0; k < 8; k++) begin
         ctl = 3'(k);
         wr(ctlw(2'b00, 27'h7FF_FFFF));
         chk("R2 R10", reg_rdata, {ctl[2], 27'b0, ctl[1], ctl[0], 2'b00});
      end

      // sweep all syndromes, alternating kind, R3 R4 R5 R9
      ctl = 3'b011;
      wr(ctlw(2'b11, '0));
      for (int s = 0; s < 256; s++) begin
         logic unc;
         unc = s[0];
         a0  = AW'(s * 24'h0B3D71 + 24'h135);
         strobe(unc, a0, 8'(s));
         chk("R4 R5", reg_rdata, word(a0, 8'(s), unc ? 2'b10 : 2'b01));
         chk("R9", {30'b0, nmi_req, serr_req}, {30'b0, !unc, unc});
         wr(ctlw(2'b11, '0));
         chk("R7", {30'b0, reg_rdata[1:0]}, 32'h0);
      end

      // R6 later errors ignored; R7 partial clears; R9 enables
      for (int e = 0; e < 4; e++) begin
         for (int first = 0; first < 2; first++) begin
            ctl = {1'b1, 2'(e)};
            wr(ctlw(2'b11, '0));
            a0 = 24'hA5A5A5 ^ AW'(e * 77 + first);
            a1 = 24'h5A5A5A;
            strobe(first[0], a0, 8'hC3);
            strobe(!first[0], a1, 8'h3C);
            strobe(first[0], a1, 8'h99);
            chk("R6", reg_rdata, word(a0, 8'hC3, first[0] ? 2'b10 : 2'b01));
            chk("R9", {30'b0, nmi_req, serr_req},
                {30'b0, !first[0] && ctl[0], first[0] && ctl[1]});
            wr(ctlw(2'b01, '1));
            chk("R7", reg_rdata, word(a0, 8'hC3, first[0] ? 2'b10 : 2'b01));
            wr(ctlw(2'b10, '1));
            chk("R7", reg_rdata, word(a0, 8'hC3, first[0] ? 2'b10 : 2'b01));
            wr(ctlw(2'b00, '1));
            chk("R7", reg_rdata, word(a0, 8'hC3, first[0] ? 2'b10 : 2'b01));
         end
      end

      // R8 strobe on same edge as clear
      ctl = 3'b000;
      wr(ctlw(2'b11, '0));
      strobe(1'b0, 24'h111111, 8'h11);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = ctlw(2'b11, '0);
      err_valid = 1'b1; err_uncorr = 1'b1; err_addr = 24'hFEDCBA; err_syn = 8'h5E;
      @(negedge clk);
      reg_we = 1'b0; err_valid = 1'b0; err_uncorr = 1'b0;
      chk("R8", reg_rdata, word(24'hFEDCBA, 8'h5E, 2'b10));

      // R3 uncorrectable never scrubs, scrub disabled blocks write-back
      ctl = 3'b100;
      wr(ctlw(2'b11, '0));
      strobe(1'b0, 24'h000020, 8'h01);
      strobe(1'b1, 24'h000040, 8'h02);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule